// File: doc/BRIEF.md
# Redundant Reference Clock Supervisor

This block watches four redundant reference clock inputs and decides which one drives the downstream clock tree. Each input has a qualifier bit from configuration and a failure pulse from an external clock monitor. When the input in use fails, the block sets that input's sticky alarm flag. It then moves to the lowest-numbered input that is both qualified and not yet flagged, records that index, and raises a busy indication for a fixed switch-over interval.

An interrupt line goes high when a new alarm flag appears or when the PLL lock indication drops. It stays high until software pulses the alarm-clear input. A rising edge on that input clears the flags, the selection record and the interrupt once, however long the input is held. A bypass input freezes all supervision. A filtered master reset returns the supervisor to its initial state. A separate output-enable path gates the reference clock without producing shortened pulses.

The control core is a three-state machine. MONITOR is the normal state. SWITCH is held while a switch-over is in progress. BYPASS is held while bypass is requested. The transitions are:
- MONITOR to SWITCH when the selected input fails and a replacement exists.
- SWITCH to MONITOR when the interval expires.
- Any state to BYPASS while bypass is high.
- BYPASS to MONITOR once bypass drops.
- Any state to MONITOR on an accepted master reset.

Top module: `refclk_supervisor`

## Requirements
- R1: After rst_n is released, clk_stat is 0000, sel_stat is 00, busy is 0 and irq is 0.
- R2: A fail_evt pulse on the input whose index equals sel_stat sets bit sel_stat of clk_stat on the next clock edge. A pulse on any other input leaves clk_stat unchanged.
- R3: On that failure, sel_stat takes the binary index of the lowest-numbered input with in_valid=1 whose clk_stat bit is 0, counting the newly set bit. If no input qualifies, sel_stat keeps its value and busy stays low.
- R4: busy is high for exactly 8 cycles, starting in the cycle after the failure edge. fail_evt pulses during those cycles have no effect.
- R5: A rising edge of alarm_clr clears clk_stat to 0000, sel_stat to 00 and irq to 0 on that clock edge. Keeping alarm_clr high does not clear again, so later failures set flags.
- R6: irq goes high on the edge where any clk_stat bit newly sets, or where pll_lock is seen falling. It stays high until it is cleared.
- R7: While bypass is 1, failures set no flags, a pll_lock fall raises no irq, and busy is 0 from the next cycle on.
- R8: master_rst clears clk_stat, sel_stat, busy and irq only after it has been sampled high on 3 consecutive edges. A 2-cycle pulse has no effect.
- R9: out_clk follows clk while out_en is applied. A change of out_en takes effect only at a falling clock edge, so no high phase is cut short or partly produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_rst | input | 1 | Master reset, accepted after 3 consecutive cycles high |
| in_valid | input | 4 | Per-input qualifier, 1 = usable |
| fail_evt | input | 4 | Per-input failure pulse from the clock monitors |
| pll_lock | input | 1 | PLL lock indication |
| bypass | input | 1 | Freezes supervision and switching |
| alarm_clr | input | 1 | Alarm clear, rising-edge one-shot |
| out_en | input | 1 | Master output enable |
| clk_stat | output | 4 | Sticky per-input alarm flags |
| sel_stat | output | 2 | Binary index of the selected input |
| busy | output | 1 | Switch-over in progress |
| irq | output | 1 | Sticky interrupt |
| out_clk | output | 1 | Gated reference clock |

## Verification
The bound checker watches, on every cycle, these properties:
- A new flag always comes with irq.
- A qualified lock fall raises irq.
- A newly started switch lands on a qualified, unflagged input.
- busy never runs longer than the interval.
- An alarm-clear edge or an accepted master reset leaves the status clean.
- Bypass suppresses flags and busy.

Only the bench scenarios show the following:
- The exact 8-cycle length of busy.
- That holding alarm_clr does not keep the flags cleared.
- That a two-cycle master reset is ignored.
- That gating out_clk never produces a shortened high phase.

// File: rtl/refclk_sup_pkg.sv
package refclk_sup_pkg;

    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_SWITCH  = 2'd1,
        ST_BYPASS  = 2'd2
    } sup_state_e;

endpackage

// File: rtl/refclk_sup_edges.sv
// Registers the alarm-clear and lock inputs and produces single-cycle
// edge strobes from them.
module refclk_sup_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_clr,
    input  logic pll_lock,
    output logic alarm_edge,
    output logic lock_fall
);

    logic alarm_q;
    logic lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            alarm_q <= alarm_clr;
            lock_q  <= pll_lock;
        end
    end

    assign alarm_edge = alarm_clr & ~alarm_q;
    assign lock_fall  = ~pll_lock & lock_q;

endmodule

// File: rtl/refclk_sup_mr_filter.sv
// Accepts the master reset only once it has been high for MIN_CYC edges in a row.
module refclk_sup_mr_filter #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_rst,
    output logic mr_act
);

    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!master_rst) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(MIN_CYC - 1)) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    assign mr_act = master_rst && (run_cnt == CW'(MIN_CYC - 1));

endmodule

// File: rtl/refclk_sup_ctrl.sv
// Control core: state machine, sticky flags, selection record and interrupt.
module refclk_sup_ctrl
    import refclk_sup_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int SW_CYC = 8,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr_act,
    input  logic             alarm_edge,
    input  logic             lock_fall,
    input  logic             bypass,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [N_IN-1:0]  fail_evt,
    output logic [N_IN-1:0]  flags,
    output logic [SEL_W-1:0] sel,
    output logic             busy,
    output logic             irq
);

    localparam int CNT_W = $clog2(SW_CYC + 1);

    sup_state_e       state, state_nxt;
    logic [CNT_W-1:0] sw_cnt;
    logic             fail_sel;
    logic             flag_rise;
    logic             start_sw;
    logic [N_IN-1:0]  flags_upd;
    logic             cand_found;
    logic [SEL_W-1:0] cand_idx;

    // A failure counts only in MONITOR, with no bypass, clear or reset pending.
    assign fail_sel  = fail_evt[sel] && (state == ST_MONITOR) && !bypass
                       && !alarm_edge && !mr_act;
    assign flag_rise = fail_sel && !flags[sel];

    always_comb begin
        flags_upd = flags;
        if (fail_sel) begin
            flags_upd[sel] = 1'b1;
        end
    end

    // Replacement search: scan downwards so the lowest index wins.
    always_comb begin
        cand_found = 1'b0;
        cand_idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (in_valid[i] && !flags_upd[i]) begin
                cand_found = 1'b1;
                cand_idx   = SEL_W'(i);
            end
        end
    end

    assign start_sw = fail_sel && cand_found;

    always_comb begin
        state_nxt = state;
        if (mr_act) begin
            state_nxt = ST_MONITOR;
        end else if (bypass) begin
            state_nxt = ST_BYPASS;
        end else begin
            unique case (state)
                ST_MONITOR: if (start_sw) state_nxt = ST_SWITCH;
                ST_SWITCH:  if (sw_cnt == CNT_W'(SW_CYC - 1)) state_nxt = ST_MONITOR;
                ST_BYPASS:  state_nxt = ST_MONITOR;
                default:    state_nxt = ST_MONITOR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_MONITOR;
        end else begin
            state <= state_nxt;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy = 1'b0;
        unique case (state)
            ST_MONITOR: busy = 1'b0;
            ST_SWITCH:  busy = 1'b1;
            ST_BYPASS:  busy = 1'b0;
            default:    busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_cnt <= '0;
        end else if (state == ST_SWITCH && state_nxt == ST_SWITCH) begin
            sw_cnt <= sw_cnt + CNT_W'(1);
        end else begin
            sw_cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            sel   <= '0;
        end else if (mr_act || alarm_edge) begin
            flags <= '0;
            sel   <= '0;
        end else begin
            flags <= flags_upd;
            if (start_sw) begin
                sel <= cand_idx;
            end
        end
    end

    // A new event takes priority over a clear arriving in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (mr_act) begin
            irq <= 1'b0;
        end else if (flag_rise || (lock_fall && !bypass)) begin
            irq <= 1'b1;
        end else if (alarm_edge) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/refclk_sup_out_gate.sv
// Enable is retimed on the falling edge, so the AND gate changes only while clk is low.
module refclk_sup_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    output logic out_clk
);

    logic en_low;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_low <= 1'b0;
        end else begin
            en_low <= out_en;
        end
    end

    assign out_clk = clk & en_low;

endmodule

// File: rtl/refclk_supervisor.sv
module refclk_supervisor #(
    parameter int N_IN   = 4,
    parameter int SW_CYC = 8,
    parameter int MR_MIN = 3,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_rst,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [N_IN-1:0]  fail_evt,
    input  logic             pll_lock,
    input  logic             bypass,
    input  logic             alarm_clr,
    input  logic             out_en,
    output logic [N_IN-1:0]  clk_stat,
    output logic [SEL_W-1:0] sel_stat,
    output logic             busy,
    output logic             irq,
    output logic             out_clk
);

    logic alarm_edge;
    logic lock_fall;
    logic mr_act;

    refclk_sup_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_clr  (alarm_clr),
        .pll_lock   (pll_lock),
        .alarm_edge (alarm_edge),
        .lock_fall  (lock_fall)
    );

    refclk_sup_mr_filter #(.MIN_CYC(MR_MIN)) u_mr (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_rst (master_rst),
        .mr_act     (mr_act)
    );

    refclk_sup_ctrl #(.N_IN(N_IN), .SW_CYC(SW_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr_act     (mr_act),
        .alarm_edge (alarm_edge),
        .lock_fall  (lock_fall),
        .bypass     (bypass),
        .in_valid   (in_valid),
        .fail_evt   (fail_evt),
        .flags      (clk_stat),
        .sel        (sel_stat),
        .busy       (busy),
        .irq        (irq)
    );

    refclk_sup_out_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .out_clk (out_clk)
    );

endmodule

// File: rtl/refclk_supervisor_chk.sv
module refclk_supervisor_chk #(
    parameter int N_IN   = 4,
    parameter int SW_CYC = 8,
    parameter int MR_MIN = 3,
    localparam int SEL_W = $clog2(N_IN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_rst,
    input logic [N_IN-1:0]  in_valid,
    input logic             pll_lock,
    input logic             bypass,
    input logic             alarm_clr,
    input logic [N_IN-1:0]  clk_stat,
    input logic [SEL_W-1:0] sel_stat,
    input logic             busy,
    input logic             irq
);

    localparam int RW = $clog2(SW_CYC + 2);

    logic          armed;
    logic [N_IN-1:0] valid_d;
    logic [RW-1:0] busy_run;
    logic [7:0]    mr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            valid_d  <= '0;
            busy_run <= '0;
            mr_run   <= '0;
        end else begin
            armed   <= 1'b1;
            valid_d <= in_valid;
            if (!busy) busy_run <= '0;
            else if (busy_run != RW'(SW_CYC)) busy_run <= busy_run + RW'(1);
            if (!master_rst) mr_run <= '0;
            else if (mr_run != 8'hFF) mr_run <= mr_run + 8'd1;
        end
    end

    p_flag_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_stat & ~$past(clk_stat)) != '0) |-> irq);

    p_lock_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(pll_lock) && !bypass && !master_rst) |=> irq);

    p_pick_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!clk_stat[sel_stat] && valid_d[sel_stat]));

    p_busy_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RW'(SW_CYC)));

    p_alarm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(alarm_clr)) |=> (clk_stat == '0 && sel_stat == '0));

    p_bypass_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> ((clk_stat & ~$past(clk_stat)) == '0));

    p_bypass_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !busy);

    p_mr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_rst && mr_run >= 8'(MR_MIN - 1)) |=>
            (clk_stat == '0 && sel_stat == '0 && !busy && !irq));

endmodule

bind refclk_supervisor refclk_supervisor_chk #(
    .N_IN(N_IN), .SW_CYC(SW_CYC), .MR_MIN(MR_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_rst (master_rst),
    .in_valid   (in_valid),
    .pll_lock   (pll_lock),
    .bypass     (bypass),
    .alarm_clr  (alarm_clr),
    .clk_stat   (clk_stat),
    .sel_stat   (sel_stat),
    .busy       (busy),
    .irq        (irq)
);

// File: tb/refclk_supervisor_test.sv
module refclk_supervisor_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, master_rst, pll_lock, bypass, alarm_clr, out_en;
    logic [3:0] in_valid, fail_evt;
    logic [3:0] clk_stat;
    logic [1:0] sel_stat;
    logic       busy, irq, out_clk;

    logic [3:0] nv_valid = 4'hF, nv_fail = 4'h0;
    logic       nv_lock = 1'b1, nv_byp = 1'b0, nv_alarm = 1'b0, nv_mr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0] stat;
        logic [1:0] sel;
        logic       busy;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    refclk_supervisor uut (
        .clk(clk), .rst_n(rst_n), .master_rst(master_rst), .in_valid(in_valid),
        .fail_evt(fail_evt), .pll_lock(pll_lock), .bypass(bypass),
        .alarm_clr(alarm_clr), .out_en(out_en), .clk_stat(clk_stat),
        .sel_stat(sel_stat), .busy(busy), .irq(irq), .out_clk(out_clk)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Driver: apply the next inputs, let one edge sample them, queue the expectation.
    task automatic step(input logic [3:0] st, input logic [1:0] se,
                        input logic b, input logic i, input string tag);
        #2;
        in_valid = nv_valid; fail_evt = nv_fail; pll_lock = nv_lock;
        bypass = nv_byp; alarm_clr = nv_alarm; master_rst = nv_mr;
        @(posedge clk);
        sb.push_back('{st, se, b, i, tag});
    endtask

    // Monitor: compare queued expectations between edges.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({clk_stat, sel_stat, busy, irq} == {e.stat, e.sel, e.busy, e.irq}, e.tag,
                  $sformatf("stat=%b sel=%0d busy=%b irq=%b", clk_stat, sel_stat, busy, irq),
                  $sformatf("stat=%b sel=%0d busy=%b irq=%b", e.stat, e.sel, e.busy, e.irq));
        end
    end

    initial begin
        rst_n = 1'b0; master_rst = 1'b0; pll_lock = 1'b1; bypass = 1'b0;
        alarm_clr = 1'b0; out_en = 1'b1; in_valid = 4'hF; fail_evt = 4'h0;
        repeat (2) @(posedge clk);
        #3;
        check({clk_stat, sel_stat, busy, irq} == 8'h00, "R1 state in reset",
              $sformatf("%b", {clk_stat, sel_stat, busy, irq}), "00000000");
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);

        step(4'b0000, 2'd0, 0, 0, "R1 idle after reset");
        nv_fail = 4'b0100;
        step(4'b0000, 2'd0, 0, 0, "R2 non-selected failure ignored");
        nv_fail = 4'b0001;
        step(4'b0001, 2'd1, 1, 1, "R2 R3 R6 failure of input 0");
        nv_fail = 4'b0010;
        step(4'b0001, 2'd1, 1, 1, "R4 failure during switch ignored");
        nv_fail = 4'b0000;
        for (int k = 0; k < 6; k++) step(4'b0001, 2'd1, 1, 1, "R4 busy held");
        step(4'b0001, 2'd1, 0, 1, "R4 busy released after 8 cycles");

        nv_valid = 4'b1011; nv_fail = 4'b0010;
        step(4'b0011, 2'd3, 1, 1, "R3 skip unqualified input 2");
        nv_fail = 4'b0000;
        for (int k = 0; k < 7; k++) step(4'b0011, 2'd3, 1, 1, "R4 busy held");
        step(4'b0011, 2'd3, 0, 1, "R4 busy released");

        nv_alarm = 1'b1;
        step(4'b0000, 2'd0, 0, 0, "R5 alarm edge clears");
        nv_fail = 4'b0001;
        step(4'b0001, 2'd1, 1, 1, "R5 held clear does not block flags");
        nv_fail = 4'b0000;
        for (int k = 0; k < 7; k++) step(4'b0001, 2'd1, 1, 1, "R4 busy held");
        step(4'b0001, 2'd1, 0, 1, "R4 busy released");

        nv_alarm = 1'b0;
        step(4'b0001, 2'd1, 0, 1, "R6 irq sticky");
        nv_alarm = 1'b1;
        step(4'b0000, 2'd0, 0, 0, "R5 second edge clears");
        nv_alarm = 1'b0; nv_lock = 1'b0;
        step(4'b0000, 2'd0, 0, 1, "R6 lock fall raises irq");
        step(4'b0000, 2'd0, 0, 1, "R6 irq stays high");
        nv_alarm = 1'b1;
        step(4'b0000, 2'd0, 0, 0, "R5 clear drops irq");
        nv_alarm = 1'b0; nv_lock = 1'b1;
        step(4'b0000, 2'd0, 0, 0, "R6 lock regained, no irq");

        nv_byp = 1'b1;
        step(4'b0000, 2'd0, 0, 0, "R7 enter bypass");
        nv_fail = 4'b0001;
        step(4'b0000, 2'd0, 0, 0, "R7 failure ignored in bypass");
        nv_fail = 4'b0000; nv_lock = 1'b0;
        step(4'b0000, 2'd0, 0, 0, "R7 lock fall ignored in bypass");
        nv_byp = 1'b0;
        step(4'b0000, 2'd0, 0, 0, "R7 leave bypass");
        nv_fail = 4'b0001;
        step(4'b0001, 2'd1, 1, 1, "R3 switch to input 1");
        nv_fail = 4'b0000; nv_byp = 1'b1;
        step(4'b0001, 2'd1, 0, 1, "R7 bypass ends switch");
        nv_byp = 1'b0;
        step(4'b0001, 2'd1, 0, 1, "R7 status kept after bypass");

        nv_valid = 4'b0011; nv_fail = 4'b0010;
        step(4'b0011, 2'd1, 0, 1, "R3 no candidate keeps selection");
        nv_fail = 4'b0000;

        nv_mr = 1'b1;
        step(4'b0011, 2'd1, 0, 1, "R8 short reset cycle 1");
        step(4'b0011, 2'd1, 0, 1, "R8 short reset cycle 2");
        nv_mr = 1'b0;
        step(4'b0011, 2'd1, 0, 1, "R8 two-cycle reset ignored");
        nv_mr = 1'b1;
        step(4'b0011, 2'd1, 0, 1, "R8 reset cycle 1");
        step(4'b0011, 2'd1, 0, 1, "R8 reset cycle 2");
        step(4'b0000, 2'd0, 0, 0, "R8 reset accepted on cycle 3");
        nv_mr = 1'b0;
        step(4'b0000, 2'd0, 0, 0, "R8 state after reset");

        // R9 gating, checked directly against out_clk
        #3;
        check(out_clk == 1'b1, "R9 enabled clock passes", $sformatf("%b", out_clk), "1");
        @(posedge clk);
        #2 out_en = 1'b0;
        #1 check(out_clk == 1'b1, "R9 high phase not cut", $sformatf("%b", out_clk), "1");
        @(posedge clk);
        #2 check(out_clk == 1'b0, "R9 gated after falling edge", $sformatf("%b", out_clk), "0");
        #1 out_en = 1'b1;
        #1 check(out_clk == 1'b0, "R9 no partial pulse", $sformatf("%b", out_clk), "0");
        @(posedge clk);
        #2 check(out_clk == 1'b1, "R9 re-enabled", $sformatf("%b", out_clk), "1");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule